// File: doc/BRIEF.md
# Display Bus Write Forwarder

This block sits beside a host that drives a character display over a parallel bus: eight data lines, a register select, a read/write select and an enable strobe. It does not take part in the bus. It watches the strobe, and on each falling edge of enable that ends a write it captures the register select and the data byte. It then sends them to a remote display as a short serial frame on a data line, together with a bit clock that the block drives itself.

Each frame closes with an even parity bit. After the frame, the block waits for a response from the far end. A positive acknowledge releases the frame. A negative acknowledge, or no response within a fixed window, sends the same frame again. After three failed attempts the frame is dropped and a sticky error flag is raised, which can drive an indicator. A write that arrives while a frame is still in progress is dropped, and a sticky overrun flag records it.

All bus inputs are asynchronous to the system clock and pass through synchronizers. Host reads are ignored.

Top module: `bus_write_serializer`

## Requirements
- R1: At the falling edge of `bus_en_i` with `bus_rw_i` low, the RS and data values present while enable was high are captured. `busy_o` rises at the fourth rising clock edge after enable falls. Data changed after the fall does not alter the frame.
- R2: A falling edge of enable with `bus_rw_i` high (a read) sends no frame and leaves `busy_o` low.
- R3: A frame has 11 bits, sent MSB first: a start bit of 1, then RS, then D7 down to D0, then parity. Each bit lasts DIV clocks. `ser_clk_o` is low for the first DIV/2 clocks of a bit and high for the rest, and the receiver samples `ser_dat_o` on the rising edge of `ser_clk_o`. While not busy, both lines are low.
- R4: The parity bit makes the total count of ones across RS, D7..D0 and parity even.
- R5: An acknowledge pulse (`ack_valid_i` high) with `ack_ok_i` low, taken while waiting, causes the identical frame to be sent again.
- R6: If no acknowledge arrives within 64 bit times after the parity bit ends, the identical frame is sent again.
- R7: A third consecutive failed attempt drops the frame, drops `busy_o` and raises `err_o` in the same clock in which that failure is taken. `err_o` stays high until cleared.
- R8: A write captured while `busy_o` is high sets `overrun_o`, which stays high until cleared. That write is never sent.
- R9: A positive acknowledge taken while waiting ends the transfer with no further frames. An acknowledge pulse that arrives while a frame is being sent is ignored.
- R10: A one-cycle pulse on `err_clr_i` clears both `err_o` and `overrun_o`, and later writes are forwarded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Display bus enable strobe (asynchronous) |
| bus_rs_i | input | 1 | Display bus register select (asynchronous) |
| bus_rw_i | input | 1 | Display bus read/write select, 1 = read (asynchronous) |
| bus_data_i | input | 8 | Display bus data lines (asynchronous) |
| ack_valid_i | input | 1 | Far-end response strobe, one cycle |
| ack_ok_i | input | 1 | Response kind: 1 = positive, 0 = negative |
| err_clr_i | input | 1 | Clears the error and overrun flags |
| ser_clk_o | output | 1 | Serial bit clock |
| ser_dat_o | output | 1 | Serial data |
| busy_o | output | 1 | A frame is being sent or awaits a response |
| err_o | output | 1 | Sticky flag: a frame failed three times |
| overrun_o | output | 1 | Sticky flag: a write was dropped while busy |

## Verification
Enable falls at a falling clock edge. `busy_o` must still be low after three rising edges and high after the fourth, and the bench samples both points on falling edges. Frames are rebuilt from the serial lines by a monitor that samples data at each rise of `ser_clk_o` and measures every high phase. After each negative acknowledge, `err_o` is read at the falling edge that follows the rising edge taking the pulse, because the flag is due in exactly that cycle. The timeout retry is checked as a window on the gap between two received frames: at least 64 bit times, and at most that plus one frame length.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/bws_capture.sv
module bws_capture #(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_vld_o,
  output logic              wr_rs_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int W    = DATA_W + 3;
  localparam int B_EN = W - 1;
  localparam int B_RS = W - 2;
  localparam int B_RW = W - 3;

  logic [W-1:0]             in_w;
  logic [SYNC_N:0][W-1:0]   stg_q;  // [SYNC_N-1] synchronized, [SYNC_N] one older
  logic                     fall_w;
  logic                     vld_q, rs_q;
  logic [DATA_W-1:0]        data_q;

  assign in_w = {en_i, rs_i, rw_i, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[SYNC_N-1:0], in_w};
  end

  // older stage still holds the values from while enable was high
  assign fall_w = stg_q[SYNC_N][B_EN] & ~stg_q[SYNC_N-1][B_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      rs_q   <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= fall_w & ~stg_q[SYNC_N][B_RW];
      if (fall_w) begin
        rs_q   <= stg_q[SYNC_N][B_RS];
        data_q <= stg_q[SYNC_N][DATA_W-1:0];
      end
    end
  end

  assign wr_vld_o  = vld_q;
  assign wr_rs_o   = rs_q;
  assign wr_data_o = data_q;

  // R1: one strobe fall yields a single-cycle capture pulse
  p_one_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);

  // R2: a capture pulse never follows a read
  p_no_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> !$past(stg_q[SYNC_N][B_RW]));
endmodule

// File: rtl/bws_tx.sv
module bws_tx
  import bws_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DIV          = 8,
  parameter int TIMEOUT_BITS = 64,
  parameter int MAX_TRIES    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic              wr_rs_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ack_vld_i,
  input  logic              ack_ok_i,
  input  logic              clr_i,
  output logic              ser_clk_o,
  output logic              ser_dat_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              ovr_o
);
  localparam int FRAME_W = DATA_W + 2;  // start, rs, data; parity follows
  localparam int CNT_W   = $clog2(DIV);
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int TO_CYC  = TIMEOUT_BITS * DIV;
  localparam int TO_W    = $clog2(TO_CYC);
  localparam int TRY_W   = $clog2(MAX_TRIES + 1);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] hold_q, shift_q;
  logic               par_q, err_q, ovr_q;
  logic [CNT_W-1:0]   div_q;
  logic [BIT_W-1:0]   bit_q;
  logic [TO_W-1:0]    to_q;
  logic [TRY_W-1:0]   tries_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      shift_q <= '0;
      par_q   <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      to_q    <= '0;
      tries_q <= '0;
      err_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (clr_i) begin
        err_q <= 1'b0;
        ovr_q <= 1'b0;
      end
      if (wr_vld_i && state_q != ST_IDLE) ovr_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (wr_vld_i) begin
          hold_q  <= {1'b1, wr_rs_i, wr_data_i};
          shift_q <= {1'b1, wr_rs_i, wr_data_i};
          par_q   <= 1'b0;
          div_q   <= '0;
          bit_q   <= '0;
          state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (div_q == CNT_W'(DIV - 1)) begin
            div_q <= '0;
            if (bit_q == BIT_W'(FRAME_W)) begin
              to_q    <= '0;
              state_q <= ST_WAIT;
            end else begin
              // parity toggles on each 1 after the start bit
              if (bit_q != '0 && shift_q[FRAME_W-1]) par_q <= ~par_q;
              shift_q <= shift_q << 1;
              bit_q   <= bit_q + 1'b1;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        ST_WAIT: begin
          to_q <= to_q + 1'b1;
          if (ack_vld_i && ack_ok_i) begin
            tries_q <= '0;
            state_q <= ST_IDLE;
          end else if (ack_vld_i || to_q == TO_W'(TO_CYC - 1)) begin
            if (tries_q == TRY_W'(MAX_TRIES - 1)) begin
              err_q   <= 1'b1;
              tries_q <= '0;
              state_q <= ST_IDLE;
            end else begin
              tries_q <= tries_q + 1'b1;
              shift_q <= hold_q;
              par_q   <= 1'b0;
              div_q   <= '0;
              bit_q   <= '0;
              state_q <= ST_SEND;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ser_clk_o = (state_q == ST_SEND) && (div_q >= CNT_W'(DIV / 2));
  assign ser_dat_o = (state_q == ST_SEND) &&
                     ((bit_q == BIT_W'(FRAME_W)) ? par_q : shift_q[FRAME_W-1]);
  assign busy_o    = (state_q != ST_IDLE);
  assign err_o     = err_q;
  assign ovr_o     = ovr_q;

  // R9: a frame in progress is never cut short by a response
  p_send_not_aborted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND) |=> (state_q != ST_IDLE));

  // R5: a negative response with tries left reloads the held frame
  p_retry_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && ack_vld_i && !ack_ok_i && tries_q < TRY_W'(MAX_TRIES - 1))
    |=> (state_q == ST_SEND && shift_q == hold_q && bit_q == '0));

  // R5: the held frame is untouched while a transfer is open
  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(hold_q));

  // R7: the error flag rises only out of the wait for a response
  p_err_from_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(state_q == ST_WAIT));

  // R7: the attempt count stays within its limit
  p_tries_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q <= TRY_W'(MAX_TRIES - 1));

  // R8: overrun rises only on a write taken while busy
  p_ovr_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(wr_vld_i && state_q != ST_IDLE));
endmodule

// File: rtl/bus_write_serializer.sv
module bus_write_serializer #(
  parameter int DATA_W       = 8,
  parameter int DIV          = 8,
  parameter int TIMEOUT_BITS = 64,
  parameter int MAX_TRIES    = 3,
  parameter int SYNC_N       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_rs_i,
  input  logic              bus_rw_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              ack_valid_i,
  input  logic              ack_ok_i,
  input  logic              err_clr_i,
  output logic              ser_clk_o,
  output logic              ser_dat_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              overrun_o
);
  logic              wr_vld, wr_rs;
  logic [DATA_W-1:0] wr_data;

  bws_capture #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (bus_en_i),
    .rs_i      (bus_rs_i),
    .rw_i      (bus_rw_i),
    .data_i    (bus_data_i),
    .wr_vld_o  (wr_vld),
    .wr_rs_o   (wr_rs),
    .wr_data_o (wr_data)
  );

  bws_tx #(
    .DATA_W(DATA_W), .DIV(DIV), .TIMEOUT_BITS(TIMEOUT_BITS), .MAX_TRIES(MAX_TRIES)
  ) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_vld_i  (wr_vld),
    .wr_rs_i   (wr_rs),
    .wr_data_i (wr_data),
    .ack_vld_i (ack_valid_i),
    .ack_ok_i  (ack_ok_i),
    .clr_i     (err_clr_i),
    .ser_clk_o (ser_clk_o),
    .ser_dat_o (ser_dat_o),
    .busy_o    (busy_o),
    .err_o     (err_o),
    .ovr_o     (overrun_o)
  );
endmodule

// File: tb/tb_bus_write_serializer.sv
module tb_bus_write_serializer;
  localparam int DIV    = 8;
  localparam int TO_CYC = 64 * DIV;
  localparam int FLEN   = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0] data = '0;
  logic       ack_v = 1'b0, ack_ok = 1'b0, clr = 1'b0;
  logic       sclk, sdat, busy, err, ovr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [FLEN-1:0] frames_q[$];
  int              ftime_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bus_write_serializer #(.DATA_W(8), .DIV(DIV), .TIMEOUT_BITS(64), .MAX_TRIES(3), .SYNC_N(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_rs_i(rs), .bus_rw_i(rw),
    .bus_data_i(data), .ack_valid_i(ack_v), .ack_ok_i(ack_ok), .err_clr_i(clr),
    .ser_clk_o(sclk), .ser_dat_o(sdat), .busy_o(busy), .err_o(err), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [FLEN-1:0] exp_frame(input logic r, input logic [7:0] d);
    return {1'b1, r, d, ^{r, d}};
  endfunction

  // line monitor: rebuilds frames, checks bit-clock shape and idle levels every clock
  logic            prev_sclk = 1'b0;
  int              nbits = 0, hi_len = 0;
  logic [FLEN-1:0] sh = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy) chk(!sclk && !sdat, "R3 idle lines", {sclk, sdat}, 0);
      if (sclk) hi_len++;
      if (!sclk && prev_sclk) begin
        chk(hi_len == DIV / 2, "R3 clock high phase", hi_len, DIV / 2);
        hi_len = 0;
      end
      if (sclk && !prev_sclk) begin
        if (nbits == 0) begin
          if (sdat) begin sh = 1; nbits = 1; end
        end else begin
          sh = {sh[FLEN-2:0], sdat};
          nbits++;
          if (nbits == FLEN) begin
            frames_q.push_back(sh);
            ftime_q.push_back(cyc);
            nbits = 0;
          end
        end
      end
      prev_sclk = sclk;
    end
  end

  task automatic bus_write(input logic r, input logic w, input logic [7:0] d, input bit lat);
    @(negedge clk); rs = r; rw = w; data = d; en = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk); data = ~d; rs = ~r;  // changes after the fall must not leak
    repeat (2) @(negedge clk);
    if (lat) chk(busy == 1'b0, "R1 busy early", busy, 0);
    @(negedge clk);
    if (lat) chk(busy == 1'b1, "R1 busy at fourth edge", busy, 1);
  endtask

  task automatic get_frame(output logic [FLEN-1:0] f, output int t, input string tag);
    int n = 0;
    while (frames_q.size() == 0 && n < 4 * TO_CYC) begin @(negedge clk); n++; end
    if (frames_q.size() == 0) begin
      chk(1'b0, {tag, " frame missing"}, 0, 1);
      f = '0; t = 0;
    end else begin
      f = frames_q.pop_front();
      t = ftime_q.pop_front();
    end
  endtask

  task automatic respond(input logic ok);
    repeat (DIV) @(negedge clk);
    ack_v = 1'b1; ack_ok = ok;
    @(negedge clk);
    ack_v = 1'b0; ack_ok = 1'b0;
  endtask

  task automatic simple_xfer(input logic r, input logic [7:0] d, input string tag);
    logic [FLEN-1:0] f; int t;
    bus_write(r, 1'b0, d, 1'b1);
    get_frame(f, t, tag);
    chk(f == exp_frame(r, d), tag, f, exp_frame(r, d));
    respond(1'b1);
    @(negedge clk);
    chk(busy == 1'b0, {tag, " R9 idle after ack"}, busy, 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [FLEN-1:0] f, f2;
    int t, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sclk, sdat, busy, err, ovr} == 5'b0, "reset outputs", {sclk, sdat, busy, err, ovr}, 0);

    // R1 R3 R4: several patterns, both parity values
    simple_xfer(1'b0, 8'hA5, "R1 R3 frame rs0 A5");
    simple_xfer(1'b1, 8'h3C, "R4 parity odd payload");
    simple_xfer(1'b1, 8'hFF, "R4 parity all ones");
    simple_xfer(1'b0, 8'h00, "R4 parity zero");

    // R2: read cycle forwards nothing
    bus_write(1'b1, 1'b1, 8'h5A, 1'b0);
    repeat (300) @(negedge clk);
    chk(busy == 1'b0, "R2 read leaves idle", busy, 0);
    chk(frames_q.size() == 0, "R2 read sends no frame", frames_q.size(), 0);

    // R5: negative response resends the same frame
    bus_write(1'b0, 1'b0, 8'h81, 1'b1);
    get_frame(f, t, "R5 first");
    respond(1'b0);
    chk(err == 1'b0, "R5 no error after one nak", err, 0);
    get_frame(f2, t2, "R5 resend");
    chk(f2 == exp_frame(1'b0, 8'h81), "R5 resent frame", f2, exp_frame(1'b0, 8'h81));
    respond(1'b1);
    repeat (2 * TO_CYC) @(negedge clk);
    chk(frames_q.size() == 0, "R9 no frame after ack", frames_q.size(), 0);

    // R9 R6: ack during send ignored, then silence forces a resend
    bus_write(1'b1, 1'b0, 8'h42, 1'b1);
    ack_v = 1'b1; ack_ok = 1'b1;
    @(negedge clk);
    ack_v = 1'b0; ack_ok = 1'b0;
    get_frame(f, t, "R6 first");
    chk(f == exp_frame(1'b1, 8'h42), "R6 first frame", f, exp_frame(1'b1, 8'h42));
    get_frame(f2, t2, "R6 timeout resend");
    chk(f2 == f, "R9 R6 resend after ignored ack", f2, f);
    chk((t2 - t) >= TO_CYC && (t2 - t) <= TO_CYC + 12 * DIV, "R6 timeout gap", t2 - t, TO_CYC);
    respond(1'b1);

    // R8: write while busy is dropped and flagged
    bus_write(1'b0, 1'b0, 8'h11, 1'b1);
    bus_write(1'b1, 1'b0, 8'h22, 1'b0);
    repeat (4) @(negedge clk);
    chk(ovr == 1'b1, "R8 overrun set", ovr, 1);
    get_frame(f, t, "R8 kept");
    chk(f == exp_frame(1'b0, 8'h11), "R8 first write kept", f, exp_frame(1'b0, 8'h11));
    respond(1'b1);
    repeat (300) @(negedge clk);
    chk(frames_q.size() == 0, "R8 dropped write not sent", frames_q.size(), 0);
    chk(ovr == 1'b1, "R8 overrun sticky", ovr, 1);

    // R7: three failures raise the error
    bus_write(1'b0, 1'b0, 8'h7E, 1'b1);
    for (int i = 0; i < 3; i++) begin
      get_frame(f, t, "R7 attempt");
      chk(f == exp_frame(1'b0, 8'h7E), "R7 attempt frame", f, exp_frame(1'b0, 8'h7E));
      respond(1'b0);
      if (i < 2) chk(err == 1'b0, "R7 error early", err, 0);
    end
    chk(err == 1'b1, "R7 error at third failure", err, 1);
    chk(busy == 1'b0, "R7 frame dropped", busy, 0);
    repeat (2 * TO_CYC) @(negedge clk);
    chk(frames_q.size() == 0, "R7 no fourth attempt", frames_q.size(), 0);
    chk(err == 1'b1, "R7 error sticky", err, 1);

    // R10: clear both flags, traffic resumes
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(err == 1'b0, "R10 error cleared", err, 0);
    chk(ovr == 1'b0, "R10 overrun cleared", ovr, 0);
    simple_xfer(1'b1, 8'h55, "R10 after clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule